// File: doc/BRIEF.md
# Two-Word Pixel Capture with Format Unpacking

This block sits behind a 12-bit video input port. The port carries each pixel as two consecutive words. The block pairs the words and unpacks the pair into a 24-bit pixel. A 3-bit format select chooses the bit layout: two orderings of full 24-bit RGB, RGB 5-6-5, RGB 5-5-5 and 8-bit 4:2:2 YCrCb with shared chroma.

There are two sampling modes, selected by a static input:

- **Single-edge mode:** the port is sampled on each rising edge of a clock running at twice the pixel rate.
- **Dual-edge mode:** the clock runs at the pixel rate. The first word is sampled on the rising edge and the second word on the following falling edge.

Horizontal and vertical sync each have a polarity bit. The leading edge of horizontal sync restarts the word pairing and the pixel count. A programmable count then marks where active video begins.

Every rebuilt pixel produces a one-cycle valid strobe with the 24-bit pixel and an active flag. Pixels outside active video carry the blanking value of the selected format. Change the mode or format only while reset is held.

Top module: `mux_pixel_capture`

## Requirements
- R1: In single-edge mode (`ddr_mode`=0), words are sampled on rising edges. The first word sampled after the sync leading edge is a first word, and each following pair of samples forms one pixel.
- R2: In dual-edge mode (`ddr_mode`=1), the word sampled on a rising edge is the first word and the word sampled on the next falling edge is the second. One pixel is produced per clock once the stream is running.
- R3: `pix_vld` is a one-cycle pulse per rebuilt pixel, with `pix_data` and `pix_act` valid in that cycle. In single-edge mode two pulses are never adjacent.
- R4: Format 0 gives R=w2[11:4], G={w2[3:0],w1[11:8]}, B=w1[7:0]. Format 1 gives R=w1[11:4], G={w1[3:0],w2[11:8]}, B=w2[7:0]. Here w1 is the first word and w2 the second, and the pixel is {R,G,B} with R in bits 23:16.
- R5: Format 2 (5-6-5) gives R={w2[7:3],000}, G={w2[2:0],w1[7:5],00}, B={w1[4:0],000}.
- R6: Format 3 (5-5-5) gives R={w2[6:2],000}, G={w2[1:0],w1[7:5],000}, B={w1[4:0],000}. Bit w2[7], and bits 11:8 of both words in formats 2 to 4, have no effect.
- R7: Format 4 (YCrCb) takes chroma from w1[7:0] and luma from w2[7:0]. Active pixels alternate Cb then Cr, starting with Cb at the first active pixel after sync. The output is {Y,Cr,Cb} using the latest Cb and Cr, and Cr reads 128 until the first Cr of the line arrives.
- R8: Format codes 5, 6 and 7 unpack exactly as format 0.
- R9: Pixels are numbered from 0 after the sync leading edge. A pixel is active when its number is at least `sav_cnt`.
- R10: `hs_low`=1 or `vs_low`=1 makes the corresponding sync input active-low.
- R11: While vertical sync is active, no pixel is active.
- R12: Inactive pixels carry 0 in the RGB formats and Y=16, Cr=128, Cb=128 in format 4.
- R13: A sync leading edge discards any half-formed pair and pending pixel state. This holds even when the edge lands in the same cycle a pair completes.
- R14: During and right after reset, `pix_vld`, `pix_act` and `pix_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock (2x pixel rate single-edge, 1x dual-edge) |
| rst_n | input | 1 | Asynchronous reset, active low |
| ddr_mode | input | 1 | 1 selects dual-edge sampling |
| fmt_sel | input | 3 | Word-pair layout select |
| hs_low | input | 1 | Horizontal sync is active-low |
| vs_low | input | 1 | Vertical sync is active-low |
| sav_cnt | input | SAV_W | Pixel number of first active pixel |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| word_in | input | 12 | Input data word |
| pix_vld | output | 1 | Pixel strobe |
| pix_data | output | 24 | Rebuilt pixel |
| pix_act | output | 1 | Pixel lies in active video |

## Verification
A sync leading edge and the completion of a word pair can fall in the same clock. The edge must win: the half pair is dropped and the next word becomes a first word. The bench provokes this by idling junk words for an odd or even number of cycles before each sync edge, so the edge meets the pairing logic in both phases. It then requires the first rebuilt pixels of the line to match the expected word pairs exactly, in both sampling modes.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int WORD_W = 12;
  localparam int PIX_W  = 24;
  localparam int FMT_W  = 3;

  localparam logic [FMT_W-1:0] FMT_RGB_LH = 3'd0;
  localparam logic [FMT_W-1:0] FMT_RGB_HL = 3'd1;
  localparam logic [FMT_W-1:0] FMT_RGB565 = 3'd2;
  localparam logic [FMT_W-1:0] FMT_RGB555 = 3'd3;
  localparam logic [FMT_W-1:0] FMT_YCC    = 3'd4;

  localparam logic [7:0] Y_BLANK = 8'd16;
  localparam logic [7:0] C_BLANK = 8'd128;

  // RGB unpacking of a word pair; w1 is the first word of the pixel
  function automatic logic [PIX_W-1:0] unpack_rgb(
      input logic [FMT_W-1:0] fmt,
      input logic [WORD_W-1:0] w1,
      input logic [WORD_W-1:0] w2);
    case (fmt)
      FMT_RGB_HL: return {w1, w2};
      FMT_RGB565: return {w2[7:3], 3'b000, w2[2:0], w1[7:5], 2'b00, w1[4:0], 3'b000};
      FMT_RGB555: return {w2[6:2], 3'b000, w2[1:0], w1[7:5], 3'b000, w1[4:0], 3'b000};
      default:    return {w2, w1};
    endcase
  endfunction

  function automatic logic [PIX_W-1:0] blank_pix(input logic [FMT_W-1:0] fmt);
    return (fmt == FMT_YCC) ? {Y_BLANK, C_BLANK, C_BLANK} : '0;
  endfunction
endpackage

// File: rtl/mpc_sync_track.sv
module mpc_sync_track (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_low,
  input  logic vs_low,
  input  logic hsync_in,
  input  logic vsync_in,
  output logic line_start,
  output logic vs_act
);
  logic hs_act;
  logic hs_q;

  assign hs_act     = hsync_in ^ hs_low;
  assign vs_act     = vsync_in ^ vs_low;
  assign line_start = hs_act & ~hs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_q <= 1'b0;
    else        hs_q <= hs_act;
  end
endmodule

// File: rtl/mpc_word_pair.sv
module mpc_word_pair #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ddr_mode,
  input  logic              line_start,
  input  logic [WORD_W-1:0] word_in,
  output logic              pair_go,
  output logic [WORD_W-1:0] pair_first,
  output logic [WORD_W-1:0] pair_second
);
  logic [WORD_W-1:0] rise_q;
  logic [WORD_W-1:0] fall_q;
  logic              phase_q;
  logic              primed_q;

  // falling-edge half of the dual-edge capture
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q      <= '0;
      phase_q     <= 1'b0;
      primed_q    <= 1'b0;
      pair_go     <= 1'b0;
      pair_first  <= '0;
      pair_second <= '0;
    end else if (line_start) begin
      phase_q  <= 1'b0;
      primed_q <= 1'b0;
      pair_go  <= 1'b0;
    end else if (ddr_mode) begin
      rise_q   <= word_in;
      primed_q <= 1'b1;
      pair_go  <= primed_q;
      if (primed_q) begin
        pair_first  <= rise_q;
        pair_second <= fall_q;
      end
    end else begin
      phase_q <= ~phase_q;
      if (!phase_q) begin
        rise_q  <= word_in;
        pair_go <= 1'b0;
      end else begin
        pair_first  <= rise_q;
        pair_second <= word_in;
        pair_go     <= 1'b1;
      end
    end
  end

  // R13
  lead_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !pair_go);
endmodule

// File: rtl/mpc_pixel_build.sv
module mpc_pixel_build
  import mpc_pkg::*;
#(
  parameter int SAV_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FMT_W-1:0]  fmt_sel,
  input  logic [SAV_W-1:0]  sav_cnt,
  input  logic              line_start,
  input  logic              vs_act,
  input  logic              pair_go,
  input  logic [WORD_W-1:0] pair_first,
  input  logic [WORD_W-1:0] pair_second,
  output logic              pair_act,
  output logic              pix_vld,
  output logic [PIX_W-1:0]  pix_data,
  output logic              pix_act
);
  logic [SAV_W-1:0] idx_q;
  logic             cr_turn_q;
  logic [7:0]       cb_q;
  logic [7:0]       cr_q;
  logic             is_ycc;
  logic [PIX_W-1:0] ycc_pix;
  logic [PIX_W-1:0] data_nxt;

  assign is_ycc   = (fmt_sel == FMT_YCC);
  assign pair_act = pair_go & ~vs_act & (idx_q >= sav_cnt);

  always_comb begin
    if (cr_turn_q) ycc_pix = {pair_second[7:0], pair_first[7:0], cb_q};
    else           ycc_pix = {pair_second[7:0], cr_q, pair_first[7:0]};
    if (!pair_act)   data_nxt = blank_pix(fmt_sel);
    else if (is_ycc) data_nxt = ycc_pix;
    else             data_nxt = unpack_rgb(fmt_sel, pair_first, pair_second);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      cr_turn_q <= 1'b0;
      cb_q      <= C_BLANK;
      cr_q      <= C_BLANK;
      pix_vld   <= 1'b0;
      pix_act   <= 1'b0;
      pix_data  <= '0;
    end else begin
      pix_vld <= pair_go;
      pix_act <= pair_act;
      if (pair_go) pix_data <= data_nxt;
      if (line_start) begin
        idx_q     <= '0;
        cr_turn_q <= 1'b0;
        cb_q      <= C_BLANK;
        cr_q      <= C_BLANK;
      end else if (pair_go) begin
        if (idx_q != {SAV_W{1'b1}}) idx_q <= idx_q + 1'b1;
        if (pair_act && is_ycc) begin
          cr_turn_q <= ~cr_turn_q;
          if (cr_turn_q) cr_q <= pair_first[7:0];
          else           cb_q <= pair_first[7:0];
        end
      end
    end
  end

  // R12
  blank_rgb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !pix_act && $past(fmt_sel) != FMT_YCC) |-> pix_data == '0);
endmodule

// File: rtl/mux_pixel_capture.sv
module mux_pixel_capture
  import mpc_pkg::*;
#(
  parameter int SAV_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ddr_mode,
  input  logic [FMT_W-1:0]  fmt_sel,
  input  logic              hs_low,
  input  logic              vs_low,
  input  logic [SAV_W-1:0]  sav_cnt,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic [WORD_W-1:0] word_in,
  output logic              pix_vld,
  output logic [PIX_W-1:0]  pix_data,
  output logic              pix_act
);
  logic              line_start_w;
  logic              vs_act_w;
  logic              pair_go_w;
  logic              pair_act_w;
  logic [WORD_W-1:0] pair_first_w;
  logic [WORD_W-1:0] pair_second_w;

  mpc_sync_track u_sync (
    .clk(clk), .rst_n(rst_n), .hs_low(hs_low), .vs_low(vs_low),
    .hsync_in(hsync_in), .vsync_in(vsync_in),
    .line_start(line_start_w), .vs_act(vs_act_w));

  mpc_word_pair #(.WORD_W(WORD_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .ddr_mode(ddr_mode), .line_start(line_start_w),
    .word_in(word_in), .pair_go(pair_go_w),
    .pair_first(pair_first_w), .pair_second(pair_second_w));

  mpc_pixel_build #(.SAV_W(SAV_W)) u_build (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .sav_cnt(sav_cnt),
    .line_start(line_start_w), .vs_act(vs_act_w), .pair_go(pair_go_w),
    .pair_first(pair_first_w), .pair_second(pair_second_w),
    .pair_act(pair_act_w), .pix_vld(pix_vld), .pix_data(pix_data),
    .pix_act(pix_act));

  // R11
  vs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_act |-> !$past(vs_act_w));

  // R3
  sdr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !ddr_mode && !$past(ddr_mode) && !$past(ddr_mode, 2)) |=> !pix_vld);

  // R3
  act_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_act && !pair_act_w) |-> pix_vld);
endmodule

// File: tb/sim_mux_pixel_capture.sv
module sim_mux_pixel_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ddr_mode = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic        hs_low = 1'b0;
  logic        vs_low = 1'b0;
  logic [8:0]  sav_cnt = 9'd0;
  logic        hsync_in = 1'b0;
  logic        vsync_in = 1'b0;
  logic [11:0] word_in = 12'd0;
  logic        pix_vld;
  logic [23:0] pix_data;
  logic        pix_act;

  int n_chk = 0;
  int n_bad = 0;
  int line_no = 0;
  localparam int NPIX = 6;

  logic        mon_on = 1'b0;
  int          mon_cnt = 0;
  int          b2b_cnt = 0;
  logic        prev_vld = 1'b0;
  logic [23:0] got_d [16];
  logic        got_a [16];

  always #5 clk = ~clk;

  mux_pixel_capture u0 (
    .clk(clk), .rst_n(rst_n), .ddr_mode(ddr_mode), .fmt_sel(fmt_sel),
    .hs_low(hs_low), .vs_low(vs_low), .sav_cnt(sav_cnt),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .word_in(word_in),
    .pix_vld(pix_vld), .pix_data(pix_data), .pix_act(pix_act));

  always @(negedge clk) begin
    if (mon_on) begin
      if (pix_vld && prev_vld) b2b_cnt++;
      if (pix_vld && mon_cnt < 16) begin
        got_d[mon_cnt] = pix_data;
        got_a[mon_cnt] = pix_act;
        mon_cnt++;
      end
    end
    prev_vld = pix_vld;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (line %0d)", tag, act, exp, line_no);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R14 outputs quiet under reset
    check("R14", {30'd0, pix_vld, pix_act}, 32'd0);
    check("R14", {8'd0, pix_data}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R14", {7'd0, pix_vld, pix_data}, 32'd0);
  endtask

  function automatic logic [23:0] exp_rgb(input logic [2:0] f,
                                          input logic [11:0] a, input logic [11:0] b);
    logic [7:0] r, g, bl;
    if (f == 3'd1) begin
      r = a[11:4]; g = {a[3:0], b[11:8]}; bl = b[7:0];
    end else if (f == 3'd2) begin
      r = {b[7:3], 3'b0}; g = {b[2:0], a[7:5], 2'b0}; bl = {a[4:0], 3'b0};
    end else if (f == 3'd3) begin
      r = {b[6:2], 3'b0}; g = {b[1:0], a[7:5], 3'b0}; bl = {a[4:0], 3'b0};
    end else begin
      r = b[11:4]; g = {b[3:0], a[11:8]}; bl = a[7:0];
    end
    return {r, g, bl};
  endfunction

  task automatic run_line(input int sav, input bit vs_on, input int tail);
    logic [11:0] w1 [NPIX];
    logic [11:0] w2 [NPIX];
    logic [23:0] ex_d [NPIX];
    logic        ex_a [NPIX];
    logic [7:0]  cb = 8'd128;
    logic [7:0]  cr = 8'd128;
    bit          odd = 1'b0;
    string       tag;
    line_no++;
    mon_on = 1'b0;
    sav_cnt = 9'(sav);
    vsync_in = vs_on ^ vs_low;
    for (int t = 0; t < tail; t++) begin
      word_in = 12'(t * 311 + line_no);
      @(negedge clk); #1;
    end
    hsync_in = 1'b1 ^ hs_low;
    word_in = 12'hABC;
    @(negedge clk); #1;
    mon_on = 1'b1; mon_cnt = 0; b2b_cnt = 0;
    hsync_in = 1'b0 ^ hs_low;
    for (int i = 0; i < NPIX; i++) begin
      w1[i] = 12'(i * 421 + line_no * 97 + 13);
      w2[i] = 12'(i * 733 + line_no * 59 + 2000);
      ex_a[i] = !vs_on && (i >= sav);
      if (!ex_a[i]) ex_d[i] = (fmt_sel == 3'd4) ? 24'h108080 : 24'h0;
      else if (fmt_sel == 3'd4) begin
        if (!odd) cb = w1[i][7:0]; else cr = w1[i][7:0];
        odd = !odd;
        ex_d[i] = {w2[i][7:0], cr, cb};
      end else ex_d[i] = exp_rgb(fmt_sel, w1[i], w2[i]);
    end
    for (int i = 0; i < NPIX; i++) begin
      word_in = w1[i];
      if (ddr_mode) begin
        @(posedge clk); #2;
        word_in = w2[i];
        @(negedge clk); #1;
      end else begin
        @(negedge clk); #1;
        word_in = w2[i];
        @(negedge clk); #1;
      end
    end
    word_in = 12'h5A5;
    repeat (4) @(negedge clk);
    #1;
    mon_on = 1'b0;
    // R13 tail length changes the phase the sync edge meets; R1/R2 pixel rate
    tag = (tail % 2 == 1) ? "R13" : (ddr_mode ? "R2" : "R1");
    check(tag, 32'(mon_cnt >= NPIX), 32'd1);
    // R3 no adjacent strobes in single-edge mode
    if (!ddr_mode) check("R3", 32'(b2b_cnt), 32'd0);
    for (int i = 0; i < NPIX; i++) begin
      if (vs_on) tag = "R11";
      else if (!ex_a[i]) tag = "R12";
      else case (fmt_sel)
        3'd0, 3'd1: tag = "R4";
        3'd2: tag = "R5";
        3'd3: tag = "R6";
        3'd4: tag = "R7";
        default: tag = "R8";
      endcase
      check(tag, {8'd0, got_d[i]}, {8'd0, ex_d[i]});
      check(hs_low ? "R10" : "R9", 32'(got_a[i]), 32'(ex_a[i]));
    end
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      for (int f = 0; f < 8; f++) begin
        for (int p = 0; p < 2; p++) begin
          ddr_mode = m[0];
          fmt_sel = 3'(f);
          hs_low = p[0];
          vs_low = p[0];
          hsync_in = p[0];
          vsync_in = p[0];
          do_reset();
          run_line(p ? 3 : 1, 1'b0, 2);
          run_line(0, 1'b0, 3);
          run_line(2, 1'b0, 0);
          if (f == 4 || f == 0) run_line(0, 1'b1, 1);
        end
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule